// File: doc/BRIEF.md
# Delayed-Write Parity Responder

This block is the target-side front end of one port of a bus-to-bus bridge. When an initiator on the attached PCI-style bus issues a single-phase write, the block claims it and captures the address, command, data and byte enables. It then holds off any response until the initiator has driven the parity bit for the data phase, so that the parity of the request is known before the block answers.

The answer depends on that parity and on a response-enable input. A good request, or a bad request while the enable is 0, gets a retry. On that retry the captured request is pushed into the bridge's forwarding queue if the queue has room. A bad request while the enable is 1 is instead completed with data and dropped. A one-clock parity-error strobe then follows two clocks after the target-ready strobe. In that case the block also sets a sticky detected-parity-error status bit, and it sets a matching interrupt-status bit unless the interrupt mask is set.

The forwarding queue, the far-side completion and the register file that clears the status bits are outside this block. They connect through the push port and the clear pulses.

Top module: `dwp_target`

## Requirements
- R1: A write request (address-phase command with `cbe_n[0]`=1) gets `devsel_n` low from the clock after its address phase through its response clock. The response strobe (`stop_n` or `trdy_n`) goes low only on the clock after the cycle in which PAR for the data phase is sampled, which is two clocks after the data phase. The strobe stays low for exactly one clock.
- R2: With a parity error and `perr_resp_en`=1, `trdy_n` goes low for one clock and `stop_n` stays high.
- R3: In the R2 case, `perr_n` goes low two clocks after `trdy_n` goes low and stays low for exactly one clock. In every other case `perr_n` stays high.
- R4: In the R2 case, `q_push` is not asserted for the request.
- R5: `sts_dpe` is set one clock after `trdy_n` goes low in the R2 case, and in no other case. It stays set until cleared.
- R6: `isr_dpe` is set together with `sts_dpe` when `int_mask`=0. When `int_mask`=1 it is left unchanged.
- R7: With a parity error and `perr_resp_en`=0, the block answers with `stop_n` low, pushes the request as in R8, and leaves `perr_n`, `sts_dpe` and `isr_dpe` untouched.
- R8: With good parity the block answers with `stop_n` low. In that same clock, `q_push` is high for one clock. The push carries `q_addr` (AD in the address phase), `q_cmd` (C/BE# in the address phase), `q_data` (AD in the data phase) and `q_be` (the inverse of C/BE# in the data phase).
- R9: Parity is even over the 32 AD bits and 4 C/BE# bits of the data phase. PAR is sampled one clock after the data phase, and a mismatch is a parity error.
- R10: If `q_full` is 1 in the clock where PAR is sampled, the retry is given without a push. The R2 to R6 rules still apply.
- R11: A one-clock pulse on `sts_clr` or `isr_clr` clears the matching status bit. A set in the same clock takes priority over the clear.
- R12: Once a request has been claimed, further FRAME# activity is ignored until FRAME# and IRDY# are both seen high. A request whose address-phase `cbe_n[0]` is 0 is not claimed, and it too is ignored until the bus is idle.
- R13: After reset every strobe (`devsel_n`, `trdy_n`, `stop_n`, `perr_n`) is high, `q_push` is 0 and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Initiator frame strobe, active low |
| irdy_n | input | 1 | Initiator ready strobe, active low |
| ad | input | AD_W | Multiplexed address/data bus |
| cbe_n | input | AD_W/8 | Command / byte-enable lines, active low enables |
| par | input | 1 | Even parity over AD and C/BE# of the previous clock |
| perr_resp_en | input | 1 | Enables completion with error reporting on bad parity |
| int_mask | input | 1 | Masks the interrupt-status parity bit when 1 |
| q_full | input | 1 | Forwarding queue has no room |
| sts_clr | input | 1 | Write-one-to-clear pulse for `sts_dpe` |
| isr_clr | input | 1 | Write-one-to-clear pulse for `isr_dpe` |
| devsel_n | output | 1 | Target claims the request, active low |
| trdy_n | output | 1 | Target ready: completes the request with data |
| stop_n | output | 1 | Target stop: retry |
| perr_n | output | 1 | Data parity error report, active low |
| q_push | output | 1 | One-clock push into the forwarding queue |
| q_addr | output | AD_W | Captured request address |
| q_data | output | AD_W | Captured write data |
| q_be | output | AD_W/8 | Captured byte enables, active high |
| q_cmd | output | AD_W/8 | Captured bus command |
| sts_dpe | output | 1 | Sticky detected-parity-error status |
| isr_dpe | output | 1 | Sticky detected-parity-error interrupt status |

## Verification
The bench builds the block with `AD_W`=32 and `PERR_LAG`=2. With those values there are four command/byte-enable lanes, matching the even-parity rule over 36 bits. The two-clock error report then falls inside the seven-clock window each transaction spans, so the bench can check that pulse against the preceding target-ready strobe. Because every queue address, data and byte-enable value is reachable at 32 bits, random values expose swapped or shifted capture fields. The random mix of response enable, mask and queue-full covers every combination of completion, forwarded retry and push-less retry.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

  // Request-handling phases of the target
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for an address phase
    ST_ADDR = 3'd1,  // claimed, waiting for the data phase
    ST_PARW = 3'd2,  // data captured, waiting for PAR
    ST_RESP = 3'd3,  // response strobe on the bus
    ST_TURN = 3'd4   // waiting for FRAME# and IRDY# to go idle
  } dwp_state_e;

  localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/dwp_parity.sv
module dwp_parity #(
  parameter int unsigned AD_W = 32
) (
  input  logic [AD_W-1:0]                 ad,
  input  logic [AD_W/dwp_pkg::LANE_W-1:0] cbe_n,
  output logic                            odd
);
  localparam int unsigned LANES = AD_W / dwp_pkg::LANE_W;

  logic [LANES-1:0] lane_x;

  // one XOR tree per byte lane, folded at the end
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_x[g] = ^{ad[g*dwp_pkg::LANE_W +: dwp_pkg::LANE_W], cbe_n[g]};
  end

  assign odd = ^lane_x;

endmodule

// File: rtl/dwp_ctrl.sv
module dwp_ctrl
  import dwp_pkg::*;
#(
  parameter int unsigned AD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_n,
  input  logic                  irdy_n,
  input  logic [AD_W-1:0]       ad,
  input  logic [AD_W/LANE_W-1:0] cbe_n,
  input  logic                  par,
  input  logic                  par_odd,
  input  logic                  perr_resp_en,
  input  logic                  q_full,
  output logic                  devsel_n,
  output logic                  trdy_n,
  output logic                  stop_n,
  output logic                  q_push,
  output logic [AD_W-1:0]       q_addr,
  output logic [AD_W-1:0]       q_data,
  output logic [AD_W/LANE_W-1:0] q_be,
  output logic [AD_W/LANE_W-1:0] q_cmd,
  output logic                  cmpl_err
);
  localparam int unsigned LANES = AD_W / LANE_W;

  dwp_state_e st;
  logic       calc_q;   // parity of the data phase, awaiting PAR
  logic       bad_par;

  assign bad_par = calc_q ^ par;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      q_push   <= 1'b0;
      cmpl_err <= 1'b0;
      calc_q   <= 1'b0;
      q_addr   <= '0;
      q_data   <= '0;
      q_be     <= '0;
      q_cmd    <= '0;
    end else begin
      q_push   <= 1'b0;
      cmpl_err <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (!frame_n) begin
            if (cbe_n[0]) begin
              q_addr   <= ad;
              q_cmd    <= cbe_n;
              devsel_n <= 1'b0;
              st       <= ST_ADDR;
            end else begin
              st <= ST_TURN;
            end
          end
        end
        ST_ADDR: begin
          if (!irdy_n) begin
            q_data <= ad;
            q_be   <= ~cbe_n;
            calc_q <= par_odd;
            st     <= ST_PARW;
          end
        end
        ST_PARW: begin
          if (bad_par && perr_resp_en) begin
            trdy_n   <= 1'b0;
            cmpl_err <= 1'b1;
          end else begin
            stop_n <= 1'b0;
            q_push <= !q_full;
          end
          st <= ST_RESP;
        end
        ST_RESP: begin
          trdy_n   <= 1'b1;
          stop_n   <= 1'b1;
          devsel_n <= 1'b1;
          st       <= ST_TURN;
        end
        ST_TURN: begin
          if (frame_n && irdy_n) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic unused_lanes;
  assign unused_lanes = (LANES == 0);

endmodule

// File: rtl/dwp_status.sv
module dwp_status #(
  parameter int unsigned PERR_LAG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmpl_err,
  input  logic int_mask,
  input  logic sts_clr,
  input  logic isr_clr,
  output logic perr_n,
  output logic sts_dpe,
  output logic isr_dpe
);
  localparam int unsigned SH_W = (PERR_LAG > 2) ? PERR_LAG - 1 : 1;

  logic [SH_W-1:0] sh;

  // delay line between the completion event and the error strobe
  if (PERR_LAG > 2) begin : g_long
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SH_W-2:0], cmpl_err};
    end
  end else begin : g_short
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= cmpl_err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) perr_n <= 1'b1;
    else     perr_n <= ~sh[SH_W-1];
  end

  // sticky bits, set beats clear
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_dpe <= 1'b0;
      isr_dpe <= 1'b0;
    end else begin
      if (cmpl_err)     sts_dpe <= 1'b1;
      else if (sts_clr) sts_dpe <= 1'b0;
      if (cmpl_err && !int_mask) isr_dpe <= 1'b1;
      else if (isr_clr)          isr_dpe <= 1'b0;
    end
  end

endmodule

// File: rtl/dwp_target.sv
module dwp_target #(
  parameter int unsigned AD_W     = 32,
  parameter int unsigned PERR_LAG = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           frame_n,
  input  logic                           irdy_n,
  input  logic [AD_W-1:0]                ad,
  input  logic [AD_W/dwp_pkg::LANE_W-1:0] cbe_n,
  input  logic                           par,
  input  logic                           perr_resp_en,
  input  logic                           int_mask,
  input  logic                           q_full,
  input  logic                           sts_clr,
  input  logic                           isr_clr,
  output logic                           devsel_n,
  output logic                           trdy_n,
  output logic                           stop_n,
  output logic                           perr_n,
  output logic                           q_push,
  output logic [AD_W-1:0]                q_addr,
  output logic [AD_W-1:0]                q_data,
  output logic [AD_W/dwp_pkg::LANE_W-1:0] q_be,
  output logic [AD_W/dwp_pkg::LANE_W-1:0] q_cmd,
  output logic                           sts_dpe,
  output logic                           isr_dpe
);
  logic par_odd;
  logic cmpl_err;

  dwp_parity #(.AD_W(AD_W)) i_parity (
    .ad    (ad),
    .cbe_n (cbe_n),
    .odd   (par_odd)
  );

  dwp_ctrl #(.AD_W(AD_W)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .frame_n      (frame_n),
    .irdy_n       (irdy_n),
    .ad           (ad),
    .cbe_n        (cbe_n),
    .par          (par),
    .par_odd      (par_odd),
    .perr_resp_en (perr_resp_en),
    .q_full       (q_full),
    .devsel_n     (devsel_n),
    .trdy_n       (trdy_n),
    .stop_n       (stop_n),
    .q_push       (q_push),
    .q_addr       (q_addr),
    .q_data       (q_data),
    .q_be         (q_be),
    .q_cmd        (q_cmd),
    .cmpl_err     (cmpl_err)
  );

  dwp_status #(.PERR_LAG(PERR_LAG)) i_status (
    .clk      (clk),
    .rst      (rst),
    .cmpl_err (cmpl_err),
    .int_mask (int_mask),
    .sts_clr  (sts_clr),
    .isr_clr  (isr_clr),
    .perr_n   (perr_n),
    .sts_dpe  (sts_dpe),
    .isr_dpe  (isr_dpe)
  );

endmodule

// File: rtl/dwp_target_chk.sv
module dwp_target_chk #(
  parameter int unsigned PERR_LAG = 2
) (
  input logic clk,
  input logic rst,
  input logic irdy_n,
  input logic q_full,
  input logic int_mask,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic perr_n,
  input logic q_push,
  input logic sts_dpe,
  input logic isr_dpe
);

  AST_STOP_AFTER_PAR: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_n) |-> (!$past(irdy_n) && !$past(irdy_n, 2)));            // R1

  AST_RESP_CLAIMED: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n || !stop_n) |-> !devsel_n);                                  // R1

  AST_RESP_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n || !stop_n) |=> (trdy_n && stop_n));                         // R1

  AST_TRDY_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!trdy_n && !stop_n));                                               // R2

  AST_PERR_LAG: assert property (@(posedge clk) disable iff (rst)
    $fell(perr_n) |-> $past(!trdy_n, PERR_LAG));                          // R3

  AST_PERR_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    !perr_n |=> perr_n);                                                  // R3

  AST_NO_PUSH_ON_CMPL: assert property (@(posedge clk) disable iff (rst)
    q_push |-> (trdy_n && !stop_n));                                      // R4

  AST_STS_ONLY_CMPL: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_dpe) |-> $past(!trdy_n));                                   // R5

  AST_ISR_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    $rose(isr_dpe) |-> ($past(!int_mask) && $past(!trdy_n)));             // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    q_push |-> !$past(q_full));                                           // R10

endmodule

bind dwp_target dwp_target_chk #(.PERR_LAG(PERR_LAG)) i_dwp_chk (
  .clk      (clk),
  .rst      (rst),
  .irdy_n   (irdy_n),
  .q_full   (q_full),
  .int_mask (int_mask),
  .devsel_n (devsel_n),
  .trdy_n   (trdy_n),
  .stop_n   (stop_n),
  .perr_n   (perr_n),
  .q_push   (q_push),
  .sts_dpe  (sts_dpe),
  .isr_dpe  (isr_dpe)
);

// File: tb/test_dwp_target.sv
`timescale 1ns/1ps
module test_dwp_target;
  localparam int unsigned AD_W = 32;
  localparam int unsigned LN   = AD_W / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, par = 1'b0;
  logic [AD_W-1:0] ad = '0;
  logic [LN-1:0] cbe_n = '1;
  logic perr_resp_en = 1'b0, int_mask = 1'b0, q_full = 1'b0;
  logic sts_clr = 1'b0, isr_clr = 1'b0;
  logic devsel_n, trdy_n, stop_n, perr_n, q_push, sts_dpe, isr_dpe;
  logic [AD_W-1:0] q_addr, q_data;
  logic [LN-1:0] q_be, q_cmd;

  int total = 0;
  int bad = 0;
  logic exp_sts = 1'b0;
  logic exp_isr = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  dwp_target #(.AD_W(AD_W), .PERR_LAG(2)) i_dwp_target (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
    .cbe_n(cbe_n), .par(par), .perr_resp_en(perr_resp_en), .int_mask(int_mask),
    .q_full(q_full), .sts_clr(sts_clr), .isr_clr(isr_clr), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .perr_n(perr_n), .q_push(q_push),
    .q_addr(q_addr), .q_data(q_data), .q_be(q_be), .q_cmd(q_cmd),
    .sts_dpe(sts_dpe), .isr_dpe(isr_dpe)
  );

  function automatic logic even_par(input logic [AD_W-1:0] d, input logic [LN-1:0] b);
    return ^{d, b};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one single-phase write; inj flips PAR, hold keeps IRDY# low and re-raises FRAME# after the response
  task automatic write_txn(input logic [AD_W-1:0] a, input logic [AD_W-1:0] d,
                           input logic [LN-1:0] cmd, input logic [LN-1:0] be_n,
                           input logic inj, input logic en, input logic msk,
                           input logic full, input logic clr_at_set, input logic hold);
    logic cmpl;
    cmpl = inj && en;
    perr_resp_en = en; int_mask = msk;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = cmd; par = $urandom;
    @(negedge clk);
    chk(devsel_n == 1'b0, "R1 devsel", devsel_n, 0);
    frame_n = 1'b1; irdy_n = 1'b0; ad = d; cbe_n = be_n;
    @(negedge clk);
    chk(stop_n && trdy_n, "R1 early response", {stop_n, trdy_n}, 2'b11);
    par = even_par(d, be_n) ^ inj; q_full = full;
    @(negedge clk);
    if (cmpl) begin
      chk(trdy_n == 1'b0 && stop_n == 1'b1, "R2 trdy", {trdy_n, stop_n}, 2'b01);
      chk(q_push == 1'b0, "R4 push", q_push, 0);
    end else begin
      chk(stop_n == 1'b0 && trdy_n == 1'b1, inj ? "R7 stop" : "R8 stop", {stop_n, trdy_n}, 2'b01);
      chk(q_push == !full, full ? "R10 push" : "R8 push", q_push, !full);
      if (!full) begin
        chk(q_addr == a && q_cmd == cmd, "R8 addr/cmd", {q_addr, 28'h0, q_cmd}, {a, 28'h0, cmd});
        chk(q_data == d && q_be == ~be_n, "R8 data/be", {q_data, 28'h0, q_be}, {d, 28'h0, ~be_n});
      end
    end
    chk(perr_n == 1'b1, "R3 perr early", perr_n, 1);
    if (clr_at_set) begin sts_clr = 1'b1; isr_clr = 1'b1; end
    @(negedge clk);
    sts_clr = 1'b0; isr_clr = 1'b0;
    if (cmpl) begin exp_sts = 1'b1; if (!msk) exp_isr = 1'b1; end
    else if (clr_at_set) begin exp_sts = 1'b0; exp_isr = 1'b0; end
    if (cmpl && msk && clr_at_set) exp_isr = 1'b0;
    chk(trdy_n && stop_n && devsel_n, "R1 release", {trdy_n, stop_n, devsel_n}, 3'b111);
    chk(sts_dpe == exp_sts, cmpl ? "R5 sts" : "R7 sts", sts_dpe, exp_sts);
    chk(isr_dpe == exp_isr, "R6 isr", isr_dpe, exp_isr);
    if (hold) begin frame_n = 1'b0; cbe_n = 4'b0111; ad = $urandom; end
    else irdy_n = 1'b1;
    @(negedge clk);
    chk(perr_n == !cmpl, "R3 perr pulse", perr_n, !cmpl);
    if (hold) chk(devsel_n && !q_push, "R12 busy ignore", {devsel_n, q_push}, 2'b10);
    @(negedge clk);
    chk(perr_n == 1'b1, "R3 perr one clk", perr_n, 1);
    if (hold) chk(devsel_n && !q_push, "R12 busy ignore", {devsel_n, q_push}, 2'b10);
    frame_n = 1'b1; irdy_n = 1'b1; q_full = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({devsel_n, trdy_n, stop_n, perr_n} == 4'hF, "R13 strobes", {devsel_n, trdy_n, stop_n, perr_n}, 4'hF);
    chk(!q_push && !sts_dpe && !isr_dpe, "R13 push/status", {q_push, sts_dpe, isr_dpe}, 0);

    // directed corners
    write_txn(32'h1000_0040, 32'hA5A5_0F0F, 4'b0111, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R8 R9 good
    write_txn(32'h2000_0000, 32'h0000_0001, 4'b0111, 4'b1110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R7
    write_txn(32'h3000_0004, 32'hFFFF_FFFF, 4'b0011, 4'b0101, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R2 masked, R6
    write_txn(32'h4000_0008, 32'h1234_5678, 4'b1111, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R10 with error
    write_txn(32'h5000_000C, 32'h8765_4321, 4'b0111, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); // R10, R12 hold

    // R11 clear pulses
    sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0; exp_sts = 1'b0;
    chk(sts_dpe == 1'b0, "R11 sts clear", sts_dpe, 0);
    chk(isr_dpe == 1'b1, "R11 isr untouched", isr_dpe, 1);
    isr_clr = 1'b1; @(negedge clk); isr_clr = 1'b0; exp_isr = 1'b0;
    chk(isr_dpe == 1'b0, "R11 isr clear", isr_dpe, 0);
    // R11 set beats clear
    write_txn(32'h6000_0010, 32'h0F0F_F0F0, 4'b0111, 4'b1000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);

    // R12 read not claimed
    @(negedge clk); frame_n = 1'b0; cbe_n = 4'b0110; ad = 32'h7000_0000;
    @(negedge clk); frame_n = 1'b1; irdy_n = 1'b0; ad = 32'hDEAD_BEEF; cbe_n = 4'b0000;
    repeat (3) begin
      @(negedge clk);
      chk(devsel_n && stop_n && trdy_n && !q_push, "R12 read ignored",
          {devsel_n, stop_n, trdy_n, q_push}, 4'b1110);
    end
    irdy_n = 1'b1; @(negedge clk);

    // random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 300; i++) begin
      logic [3:0] cm;
      cm = {$urandom_range(3, 0), 2'b11};
      write_txn($urandom, $urandom, cm, 4'($urandom), ($urandom_range(2, 0) == 0),
                1'($urandom), 1'($urandom), ($urandom_range(3, 0) == 0),
                ($urandom_range(7, 0) == 0), ($urandom_range(9, 0) == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule